// File: doc/BRIEF.md
# I2C Serial EEPROM Slave

This block is a two-wire bus target that acts like a small byte-addressed serial EEPROM. It samples the clock and data lines of the bus with the system clock, finds the start and stop conditions, and decodes a control byte, a word address and data bytes. It answers by pulling the data line low through an output enable. The clock line is an input only, because the block never stretches the clock. A pointer register holds the current address. Write transfers load it, and every byte read or written moves it forward.

The storage array has 256, 512 or 1024 bytes (`MEM_BYTES`), split into 256-byte blocks. In the larger sizes the block comes from the control byte. The pointer never carries from one block into the next.

A write-protect input guards the upper half of the array in the multi-block sizes. In the 256-byte size it has no effect. A byte write reaches the array only at the stop condition that closes the transfer. Every bus input has a synchronizer and edge detector. Each transfer runs only on those single-cycle events, so there is no stream interface and no back-pressure. The bus timing is the only flow control.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: After reset the block does not drive the data line (`sda_oe_o` = 0).
- R2: The block acknowledges a control byte whose bits 7:4 are 1010. For any other control byte it gives no acknowledge, and it stays silent for the rest of the transfer, further bytes included, until the next start or stop.
- R3: A byte write is a control byte with bit 0 = 0, then a word address, then one data byte. The block acknowledges all three, stores the byte at the stop condition, and a later read returns that byte.
- R4: A random read returns the byte at the given address. It is a write control byte and a word address, then a repeated start and a control byte with bit 0 = 1.
- R5: While the master acknowledges each read byte, the block sends the following bytes in order. After a master non-acknowledge and a stop, the data line is released.
- R6: A current-address read is a read control byte with no word address. It returns the byte at the pointer. The pointer is left one past the last byte read, or one past the last byte written by an accepted byte write.
- R7: The pointer wraps from offset 0xFF of a 256-byte block to offset 0x00 of the same block, both in reads and in writes.
- R8: With 512 bytes, control byte bit 1 selects the block and forms address bit 8. With 1024 bytes, control byte bits 2:1 form address bits 9:8. Control byte bits 3 and up are ignored for addressing.
- R9: When `wp_i` is 1 in a multi-block size and the pointer is in the upper half of the array, the control byte and word address are still acknowledged. The data byte is not acknowledged, and the stop leaves the array unchanged.
- R10: When `wp_i` is 1, writes to the lower half proceed normally.
- R11: A write whose data byte was acknowledged but which ends in a repeated start instead of a stop leaves the array unchanged.
- R12: The block changes `sda_oe_o` only while the synchronized clock line is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND of all drivers) |
| wp_i | input | 1 | Write protect for the upper half of the array |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| sda_o | output | 1 | Level driven when enabled, always 0 |

## Verification
The assertions take for granted that the master changes the data line only while the clock line is low, except at start and stop conditions. They also assume each bus level lasts several system clocks, so that it passes the synchronizer, and that `wp_i` stays stable from the data byte to the stop. The bench master keeps every quarter bit at eight system clocks. It changes the data line only on the same edge as a clock fall, or later in the low phase. It changes `wp_i` only between transfers.

// File: rtl/i2c_eeprom_pkg.sv
package i2c_eeprom_pkg;
  localparam logic [3:0] CTRL_TAG = 4'b1010;
  localparam int unsigned BLOCK_BYTES = 256;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CTRL,
    ST_ADDR,
    ST_WDATA,
    ST_ACK1,
    ST_ACK2,
    ST_RDATA,
    ST_RLAST,
    ST_RACK,
    ST_RNEXT,
    ST_SKIP
  } slv_state_e;
endpackage

// File: rtl/i2c_line_sampler.sv
module i2c_line_sampler #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic [STAGES:0] scl_q;
  logic [STAGES:0] sda_q;
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= '1;
      sda_q <= '1;
    end else begin
      scl_q <= {scl_q[STAGES-1:0], scl_i};
      sda_q <= {sda_q[STAGES-1:0], sda_i};
    end
  end

  assign scl_s = scl_q[STAGES-1];
  assign sda_s = sda_q[STAGES-1];
  assign scl_p = scl_q[STAGES];
  assign sda_p = sda_q[STAGES];

  assign scl_rise  = scl_s & ~scl_p;
  assign scl_fall  = ~scl_s & scl_p;
  assign bus_start = scl_s & scl_p & sda_p & ~sda_s;
  assign bus_stop  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/eeprom_store.sv
module eeprom_store #(
  parameter int unsigned DEPTH = 512,
  parameter int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/eeprom_slave_fsm.sv
module eeprom_slave_fsm
  import i2c_eeprom_pkg::*;
#(
  parameter int unsigned AW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          bus_start,
  input  logic          bus_stop,
  input  logic          wp_i,
  input  logic [7:0]    rd_byte,
  output logic [AW-1:0] rd_addr,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic [7:0]    mem_wdata,
  output logic          sda_oe
);
  slv_state_e state_q, after_q;
  logic [2:0]    bitcnt_q;
  logic [7:0]    shreg_q;
  logic [AW-1:0] ptr_q;
  logic [AW-1:0] waddr_q;
  logic [7:0]    wdata_q;
  logic          armed_q, arm_pend_q, oe_q;

  logic [7:0]    nb;
  logic [AW-1:0] ptr_ctrl, ptr_addr, ptr_next;
  logic          prot_hit, quiet, load_now, wr_accept;

  assign nb    = {shreg_q[6:0], sda_s};
  assign quiet = ~bus_start & ~bus_stop;

  generate
    if (AW > 8) begin : g_blk
      assign ptr_ctrl = {nb[AW-8:1], ptr_q[7:0]};
      assign ptr_addr = {ptr_q[AW-1:8], nb};
      assign ptr_next = {ptr_q[AW-1:8], ptr_q[7:0] + 8'd1};
      assign prot_hit = wp_i & ptr_q[AW-1];
    end else begin : g_one
      assign ptr_ctrl = ptr_q;
      assign ptr_addr = nb;
      assign ptr_next = ptr_q + {{(AW-1){1'b0}}, 1'b1};
      assign prot_hit = 1'b0;
    end
  endgenerate

  assign load_now  = quiet & scl_fall &
                     ((state_q == ST_ACK2 && after_q == ST_RDATA) || state_q == ST_RNEXT);
  assign wr_accept = quiet & scl_rise & (state_q == ST_WDATA) &
                     (bitcnt_q == 3'd7) & ~prot_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      after_q    <= ST_IDLE;
      bitcnt_q   <= '0;
      shreg_q    <= '0;
      ptr_q      <= '0;
      waddr_q    <= '0;
      wdata_q    <= '0;
      armed_q    <= 1'b0;
      arm_pend_q <= 1'b0;
      oe_q       <= 1'b0;
    end else if (bus_start) begin
      state_q    <= ST_CTRL;
      bitcnt_q   <= '0;
      oe_q       <= 1'b0;
      armed_q    <= 1'b0;
      arm_pend_q <= 1'b0;
    end else if (bus_stop) begin
      state_q    <= ST_IDLE;
      oe_q       <= 1'b0;
      armed_q    <= 1'b0;
      arm_pend_q <= 1'b0;
    end else if (load_now) begin
      shreg_q  <= rd_byte;
      ptr_q    <= ptr_next;
      oe_q     <= ~rd_byte[7];
      bitcnt_q <= '0;
      state_q  <= ST_RDATA;
    end else begin
      unique case (state_q)
        ST_CTRL, ST_ADDR, ST_WDATA: begin
          if (scl_rise) begin
            shreg_q  <= nb;
            bitcnt_q <= bitcnt_q + 3'd1;
            if (bitcnt_q == 3'd7) begin
              if (state_q == ST_CTRL) begin
                if (nb[7:4] == CTRL_TAG) begin
                  ptr_q   <= ptr_ctrl;
                  after_q <= nb[0] ? ST_RDATA : ST_ADDR;
                  state_q <= ST_ACK1;
                end else begin
                  state_q <= ST_SKIP;
                end
              end else if (state_q == ST_ADDR) begin
                ptr_q   <= ptr_addr;
                after_q <= ST_WDATA;
                state_q <= ST_ACK1;
              end else if (prot_hit) begin
                state_q <= ST_SKIP;
              end else begin
                waddr_q    <= ptr_q;
                wdata_q    <= nb;
                ptr_q      <= ptr_next;
                arm_pend_q <= 1'b1;
                after_q    <= ST_SKIP;
                state_q    <= ST_ACK1;
              end
            end
          end
        end
        ST_ACK1: if (scl_fall) begin
          oe_q    <= 1'b1;
          state_q <= ST_ACK2;
        end
        ST_ACK2: if (scl_fall) begin
          oe_q     <= 1'b0;
          bitcnt_q <= '0;
          state_q  <= after_q;
          if (arm_pend_q) begin
            armed_q    <= 1'b1;
            arm_pend_q <= 1'b0;
          end
        end
        ST_RDATA: begin
          if (scl_rise) begin
            bitcnt_q <= bitcnt_q + 3'd1;
            if (bitcnt_q == 3'd7) state_q <= ST_RLAST;
          end else if (scl_fall) begin
            shreg_q <= {shreg_q[6:0], 1'b0};
            oe_q    <= ~shreg_q[6];
          end
        end
        ST_RLAST: if (scl_fall) begin
          oe_q    <= 1'b0;
          state_q <= ST_RACK;
        end
        ST_RACK: if (scl_rise) begin
          state_q <= sda_s ? ST_SKIP : ST_RNEXT;
        end
        default: ;
      endcase
    end
  end

  assign rd_addr   = ptr_q;
  assign mem_we    = bus_stop & armed_q;
  assign mem_waddr = waddr_q;
  assign mem_wdata = wdata_q;
  assign sda_oe    = oe_q;

  assert_stop_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stop |=> !sda_oe);
  assert_drive_low_phase_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);
  assert_skip_silent_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SKIP) |-> !sda_oe);
  assert_commit_needs_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (state_q == ST_SKIP));

  generate
    if (AW > 8) begin : g_chk
      assert_wrap_in_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (load_now || wr_accept) |=>
          (ptr_q[AW-1:8] == $past(ptr_q[AW-1:8])) &&
          (ptr_q[7:0] == $past(ptr_q[7:0]) + 8'd1));
      assert_no_protected_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !(wp_i && mem_waddr[AW-1]));
    end
  endgenerate
endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave #(
  parameter int unsigned MEM_BYTES = 512,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wp_i,
  output logic sda_oe_o,
  output logic sda_o
);
  localparam int unsigned AW = $clog2(MEM_BYTES);

  logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
  logic [7:0]    rd_byte, mem_wdata;
  logic [AW-1:0] rd_addr, mem_waddr;
  logic          mem_we;

  i2c_line_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop)
  );

  eeprom_slave_fsm #(.AW(AW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .bus_start(bus_start),
    .bus_stop(bus_stop), .wp_i(wp_i), .rd_byte(rd_byte), .rd_addr(rd_addr),
    .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
    .sda_oe(sda_oe_o)
  );

  eeprom_store #(.DEPTH(MEM_BYTES), .AW(AW)) u_store (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .raddr(rd_addr), .rdata(rd_byte)
  );

  assign sda_o = 1'b0;
endmodule

// File: tb/i2c_eeprom_slave_bench.sv
`timescale 1ns/1ps
module i2c_eeprom_slave_bench;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic wp = 1'b0;
  logic sda_oe, sda_o, sda_line;
  int total = 0;
  int bad = 0;
  int oe_viol = 0;
  logic oe_prev = 1'b0;

  always #2.5 clk = ~clk;

  assign sda_line = m_sda & ~sda_oe;

  i2c_eeprom_slave u_i2c_eeprom_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line), .wp_i(wp),
    .sda_oe_o(sda_oe), .sda_o(sda_o)
  );

  always @(posedge clk) begin
    if (rst_n && (sda_oe !== oe_prev) && m_scl) oe_viol <= oe_viol + 1;
    oe_prev <= sda_oe;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic b_start();
    m_sda = 1'b1; wq(Q);
    m_scl = 1'b1; wq(Q);
    m_sda = 1'b0; wq(Q);
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic b_stop();
    m_sda = 1'b0; wq(Q);
    m_scl = 1'b1; wq(Q);
    m_sda = 1'b1; wq(Q);
  endtask

  task automatic b_write(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wq(Q);
      m_scl = 1'b1; wq(Q);
      m_scl = 1'b0;
    end
    m_sda = 1'b1; wq(Q);
    m_scl = 1'b1; wq(Q / 2);
    ack = ~sda_line; wq(Q / 2);
    m_scl = 1'b0; wq(Q);
  endtask

  task automatic b_read(input logic give_ack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(Q);
      m_scl = 1'b1; wq(Q / 2);
      b[i] = sda_line; wq(Q / 2);
      m_scl = 1'b0;
    end
    m_sda = give_ack ? 1'b0 : 1'b1; wq(Q);
    m_scl = 1'b1; wq(Q);
    m_scl = 1'b0;
    m_sda = 1'b1;
  endtask

  function automatic logic [7:0] ctl(input logic [9:0] a, input logic rd);
    return {4'b1010, 2'b00, a[8], rd};
  endfunction

  task automatic do_write(input string req, input logic [9:0] a, input logic [7:0] d,
                          input logic exp_dack);
    logic ack;
    b_start();
    b_write(ctl(a, 1'b0), ack); chk({req, " control ack"}, ack, 1'b1);
    b_write(a[7:0], ack);       chk({req, " address ack"}, ack, 1'b1);
    b_write(d, ack);            chk({req, " data ack"}, ack, exp_dack);
    b_stop();
  endtask

  task automatic rd_check(input string req, input logic [9:0] a, input int n,
                          input logic [7:0] e [4]);
    logic ack;
    logic [7:0] got;
    b_start();
    b_write(ctl(a, 1'b0), ack);
    b_write(a[7:0], ack);
    b_start();
    b_write(ctl(a, 1'b1), ack); chk({req, " read control ack"}, ack, 1'b1);
    for (int i = 0; i < n; i++) begin
      b_read(i != n - 1, got);
      chk({req, " read data"}, got, e[i]);
    end
    b_stop();
    wq(Q);
    chk({req, " released after stop"}, sda_oe, 1'b0);
  endtask

  task automatic cur_check(input string req, input logic [9:0] blk, input logic [7:0] e);
    logic ack;
    logic [7:0] got;
    b_start();
    b_write(ctl(blk, 1'b1), ack); chk({req, " control ack"}, ack, 1'b1);
    b_read(1'b0, got);
    chk({req, " current data"}, got, e);
    b_stop();
  endtask

  task automatic t_reset();
    chk("R1 released after reset", sda_oe, 1'b0);
  endtask

  task automatic t_bad_ctrl();
    logic ack;
    b_start();
    b_write(8'h90, ack); chk("R2 foreign control nack", ack, 1'b0);
    b_write(8'hA0, ack); chk("R2 later byte ignored", ack, 1'b0);
    chk("R2 line released", sda_oe, 1'b0);
    b_stop();
    b_start();
    b_write(8'hA0, ack); chk("R2 own control ack", ack, 1'b1);
    b_stop();
  endtask

  task automatic t_write_read();
    logic [7:0] e [4];
    do_write("R3", 10'h012, 8'hA5, 1'b1);
    do_write("R3", 10'h1F0, 8'h3C, 1'b1);
    e = '{8'hA5, 8'h00, 8'h00, 8'h00};
    rd_check("R4 lower", 10'h012, 1, e);
    e = '{8'h3C, 8'h00, 8'h00, 8'h00};
    rd_check("R4 upper", 10'h1F0, 1, e);
  endtask

  task automatic t_sequential();
    logic [7:0] e [4];
    do_write("R5 fill", 10'h020, 8'h10, 1'b1);
    do_write("R5 fill", 10'h021, 8'h21, 1'b1);
    do_write("R5 fill", 10'h022, 8'h32, 1'b1);
    do_write("R5 fill", 10'h023, 8'h43, 1'b1);
    do_write("R5 fill", 10'h024, 8'h54, 1'b1);
    e = '{8'h10, 8'h21, 8'h32, 8'h43};
    rd_check("R5 sequential", 10'h020, 4, e);
    cur_check("R6 after read", 10'h000, 8'h54);
  endtask

  task automatic t_current_after_write();
    do_write("R6 fill", 10'h031, 8'h22, 1'b1);
    do_write("R6 write", 10'h030, 8'h11, 1'b1);
    cur_check("R6 after write", 10'h000, 8'h22);
  endtask

  task automatic t_wrap_and_block();
    logic [7:0] e [4];
    do_write("R7 fill", 10'h1FF, 8'h77, 1'b1);
    do_write("R7 fill", 10'h100, 8'h88, 1'b1);
    do_write("R7 fill", 10'h0FF, 8'h55, 1'b1);
    do_write("R7 fill", 10'h000, 8'h66, 1'b1);
    e = '{8'h77, 8'h88, 8'h00, 8'h00};
    rd_check("R7 wrap upper block", 10'h1FF, 2, e);
    e = '{8'h55, 8'h66, 8'h00, 8'h00};
    rd_check("R7 wrap lower block", 10'h0FF, 2, e);
    do_write("R7 write wrap", 10'h1FF, 8'h99, 1'b1);
    cur_check("R7 pointer after write wrap", 10'h100, 8'h88);
    do_write("R8 block0", 10'h045, 8'h9A, 1'b1);
    do_write("R8 block1", 10'h145, 8'hB7, 1'b1);
    e = '{8'h9A, 8'h00, 8'h00, 8'h00};
    rd_check("R8 block0", 10'h045, 1, e);
    e = '{8'hB7, 8'h00, 8'h00, 8'h00};
    rd_check("R8 block1", 10'h145, 1, e);
  endtask

  task automatic t_protect();
    logic [7:0] e [4];
    do_write("R9 fill", 10'h150, 8'h12, 1'b1);
    wp = 1'b1; wq(Q);
    do_write("R9 protected", 10'h150, 8'hEE, 1'b0);
    e = '{8'h12, 8'h00, 8'h00, 8'h00};
    rd_check("R9 unchanged", 10'h150, 1, e);
    do_write("R10 lower", 10'h050, 8'h5A, 1'b1);
    e = '{8'h5A, 8'h00, 8'h00, 8'h00};
    rd_check("R10 lower", 10'h050, 1, e);
    wp = 1'b0; wq(Q);
  endtask

  task automatic t_abort();
    logic ack;
    logic [7:0] e [4];
    do_write("R11 fill", 10'h060, 8'h01, 1'b1);
    b_start();
    b_write(ctl(10'h060, 1'b0), ack);
    b_write(8'h60, ack);
    b_write(8'hFF, ack); chk("R11 data ack", ack, 1'b1);
    b_start();
    b_stop();
    e = '{8'h01, 8'h00, 8'h00, 8'h00};
    rd_check("R11 unchanged", 10'h060, 1, e);
  endtask

  initial begin
    wq(10);
    rst_n = 1'b1;
    wq(10);
    t_reset();
    t_bad_ctrl();
    t_write_read();
    t_sequential();
    t_current_after_write();
    t_wrap_and_block();
    t_protect();
    t_abort();
    chk("R12 drive changes only with clock low", oe_viol, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule